// File: doc/BRIEF.md
# NAND Boot-Window Loader

This block is a hardware sequencer that starts running as soon as reset is released. It needs no processor help. It reads the data area of the first pages of an 8-bit multiplexed NAND device and fills a 4 KB on-chip SRAM through a plain synchronous write port. The SRAM is the processor's fetch region at address zero. The processor stays held until the whole window has been written, and the block then raises a release flag. Every NAND transaction is built from command-latch, address-latch, write-enable, read-enable and chip-enable strobes on a shared byte bus. The sequencer also watches the device's ready/busy line.

Each page is loaded in four steps:
- a read command byte,
- four address bytes (one column byte, then three row bytes that carry the page number),
- a wait for the busy phase of the device to begin and end,
- one read-enable strobe per data byte.

The spare bytes at the end of each page are never read. If the device never enters or never leaves its busy phase within a bounded time, the loader stops, raises an error flag and leaves the processor held.

Top module: `nand_boot_loader`

## Requirements
- R1: After reset, and until the first command cycle, cpu_release, load_error, ram_we, nf_cle and nf_ale are 0, and nf_ce_n, nf_we_n and nf_re_n are 1. nf_ce_n is low whenever nf_we_n or nf_re_n is low.
- R2: Each page read starts with one byte latched while nf_cle is 1, and that byte is 8'h00 (start of the data area). nf_cle and nf_ale are never 1 together.
- R3: After the command, exactly four bytes are latched with nf_ale at 1. The first is the column byte 8'h00. The next three are the page number, least significant byte first.
- R4: No read-enable strobe occurs for a page until nf_rb has gone low and then come back high after that page's last address byte.
- R5: Each page gets exactly PAGE_BYTES (512) read strobes. The byte returned by the n-th strobe of page p is written to SRAM address p*PAGE_BYTES+n, unchanged.
- R6: Every nf_we_n and nf_re_n low pulse lasts exactly STROBE_HOLD clock cycles (default 2). Every high interval between two pulses lasts at least STROBE_HOLD cycles.
- R7: Exactly PAGES*PAGE_BYTES (4096) SRAM writes occur, one per address, in ascending address order.
- R8: cpu_release rises only after the write to address 4095. Once high, it stays high until reset, no further SRAM write occurs, and nf_ce_n returns to 1.
- R9: If nf_rb does not fall, or does not rise again, within RB_LIMIT cycles, load_error is set and held. cpu_release stays 0, and no SRAM write or read strobe follows.
- R10: Pages are loaded in ascending order from page 0 to page PAGES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nf_data_o | output | 8 | Byte driven onto the NAND bus (command or address) |
| nf_data_oe | output | 1 | Drive enable for nf_data_o |
| nf_data_i | input | 8 | Byte read from the NAND bus |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_rb | input | 1 | Device ready (1) / busy (0) |
| ram_we | output | 1 | SRAM write enable |
| ram_addr | output | 12 | SRAM byte address |
| ram_wdata | output | 8 | SRAM write data |
| cpu_release | output | 1 | Processor may fetch from address zero |
| load_error | output | 1 | Ready/busy timeout occurred |

## Verification
The final SRAM write and the release of the processor are the two actions that could coincide. A design that released in the same cycle as that write, or before it, would let the processor fetch a stale last word. The bench drives a full load against a behavioural NAND model whose data pattern differs for every page and column. When cpu_release first rises, the bench checks that the scoreboard queue of expected writes is already empty. A sticky flag in the checker confirms that the address-4095 write came strictly earlier and that no write ever overlaps release.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

    typedef enum logic [2:0] {
        SEQ_START,
        SEQ_CMD,
        SEQ_ADDR,
        SEQ_BUSY,
        SEQ_READ,
        SEQ_DONE,
        SEQ_FAIL
    } seq_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef enum logic [1:0] {
        RB_WAIT_LO,
        RB_WAIT_HI,
        RB_READY,
        RB_TIMEOUT
    } rb_e;

    localparam logic [7:0] CMD_READ_AREA0 = 8'h00;
    localparam logic [7:0] COL_START      = 8'h00;
    localparam int         ADDR_BYTES     = 4;

endpackage

// File: rtl/nbl_strobe.sv
module nbl_strobe
    import nbl_pkg::*;
#(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic stb_n,
    output logic idle,
    output logic sample,
    output logic fin
);

    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } stb_t;

    stb_t s_d, s_q;
    logic last_cyc;

    assign last_cyc = (s_q.cnt == CW'(HOLD - 1));

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (go) begin
                    s_d.ph  = PH_LOW;
                    s_d.cnt = '0;
                end
            end
            PH_LOW: begin
                if (last_cyc) begin
                    s_d.ph  = PH_HIGH;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            PH_HIGH: begin
                if (last_cyc) begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign stb_n  = (s_q.ph != PH_LOW);
    assign idle   = (s_q.ph == PH_IDLE);
    assign sample = (s_q.ph == PH_LOW)  && last_cyc;
    assign fin    = (s_q.ph == PH_HIGH) && last_cyc;

endmodule

// File: rtl/nbl_rb_watch.sv
module nbl_rb_watch
    import nbl_pkg::*;
#(
    parameter int LIMIT = 1000,
    parameter int SYNC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rb,
    output logic ready,
    output logic timeout
);

    localparam int CW = $clog2(LIMIT + 1);

    logic rb_s;

    generate
        if (SYNC <= 1) begin : g_sync1
            logic rb_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rb_q <= 1'b1;
                else        rb_q <= rb;
            end
            assign rb_s = rb_q;
        end else begin : g_syncn
            logic [SYNC-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[SYNC-2:0], rb};
            end
            assign rb_s = chain_q[SYNC-1];
        end
    endgenerate

    typedef struct packed {
        rb_e           ph;
        logic [CW-1:0] cnt;
    } rbw_t;

    rbw_t w_d, w_q;
    logic expired;

    assign expired = (w_q.cnt == CW'(LIMIT - 1));

    always_comb begin
        w_d = w_q;
        if (!en) begin
            w_d.ph  = RB_WAIT_LO;
            w_d.cnt = '0;
        end else begin
            case (w_q.ph)
                RB_WAIT_LO: begin
                    if (!rb_s) begin
                        w_d.ph  = RB_WAIT_HI;
                        w_d.cnt = '0;
                    end else if (expired) begin
                        w_d.ph  = RB_TIMEOUT;
                    end else begin
                        w_d.cnt = w_q.cnt + CW'(1);
                    end
                end
                RB_WAIT_HI: begin
                    if (rb_s) begin
                        w_d.ph  = RB_READY;
                    end else if (expired) begin
                        w_d.ph  = RB_TIMEOUT;
                    end else begin
                        w_d.cnt = w_q.cnt + CW'(1);
                    end
                end
                default: w_d = w_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{ph: RB_WAIT_LO, cnt: '0};
        else        w_q <= w_d;
    end

    assign ready   = (w_q.ph == RB_READY);
    assign timeout = (w_q.ph == RB_TIMEOUT);

endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader
    import nbl_pkg::*;
#(
    parameter int PAGES       = 8,
    parameter int PAGE_BYTES  = 512,
    parameter int STROBE_HOLD = 2,
    parameter int RB_LIMIT    = 1000,
    parameter int RB_SYNC     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [7:0]  nf_data_o,
    output logic        nf_data_oe,
    input  logic [7:0]  nf_data_i,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic        nf_ce_n,
    input  logic        nf_rb,
    output logic        ram_we,
    output logic [11:0] ram_addr,
    output logic [7:0]  ram_wdata,
    output logic        cpu_release,
    output logic        load_error
);

    localparam int PAGE_W = $clog2(PAGES);
    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int AW     = PAGE_W + COL_W;

    typedef struct packed {
        seq_e              st;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
        logic [1:0]        acyc;
        logic              ce_n;
        logic              cle;
        logic              ale;
        logic              oe;
        logic [7:0]        dout;
        logic              ram_we;
        logic [AW-1:0]     ram_addr;
        logic [7:0]        ram_wdata;
        logic              rel;
        logic              err;
    } seq_t;

    seq_t r_d, r_q;

    logic        stb_go, stb_n, stb_idle, stb_sample, stb_fin;
    logic        rb_en, rb_ready, rb_tmo;
    logic [23:0] row;

    assign row   = 24'(r_q.page);
    assign rb_en = (r_q.st == SEQ_BUSY);

    nbl_strobe #(.HOLD(STROBE_HOLD)) strobe_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (stb_go),
        .stb_n  (stb_n),
        .idle   (stb_idle),
        .sample (stb_sample),
        .fin    (stb_fin)
    );

    nbl_rb_watch #(.LIMIT(RB_LIMIT), .SYNC(RB_SYNC)) rbw_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rb_en),
        .rb      (nf_rb),
        .ready   (rb_ready),
        .timeout (rb_tmo)
    );

    always_comb begin
        r_d        = r_q;
        r_d.ram_we = 1'b0;
        stb_go     = 1'b0;
        case (r_q.st)
            SEQ_START: begin
                r_d.ce_n = 1'b0;
                r_d.cle  = 1'b1;
                r_d.oe   = 1'b1;
                r_d.dout = CMD_READ_AREA0;
                r_d.st   = SEQ_CMD;
            end
            SEQ_CMD: begin
                stb_go = stb_idle;
                if (stb_fin) begin
                    r_d.cle  = 1'b0;
                    r_d.ale  = 1'b1;
                    r_d.acyc = 2'd0;
                    r_d.dout = COL_START;
                    r_d.st   = SEQ_ADDR;
                end
            end
            SEQ_ADDR: begin
                stb_go = stb_idle;
                if (stb_fin) begin
                    if (r_q.acyc == 2'(ADDR_BYTES - 1)) begin
                        r_d.ale = 1'b0;
                        r_d.oe  = 1'b0;
                        r_d.st  = SEQ_BUSY;
                    end else begin
                        r_d.acyc = r_q.acyc + 2'd1;
                        case (r_q.acyc)
                            2'd0:    r_d.dout = row[7:0];
                            2'd1:    r_d.dout = row[15:8];
                            default: r_d.dout = row[23:16];
                        endcase
                    end
                end
            end
            SEQ_BUSY: begin
                if (rb_tmo) begin
                    r_d.st = SEQ_FAIL;
                end else if (rb_ready) begin
                    r_d.col = '0;
                    r_d.st  = SEQ_READ;
                end
            end
            SEQ_READ: begin
                stb_go = stb_idle;
                if (stb_sample) begin
                    r_d.ram_we    = 1'b1;
                    r_d.ram_addr  = {r_q.page, r_q.col};
                    r_d.ram_wdata = nf_data_i;
                end
                if (stb_fin) begin
                    if (r_q.col == COL_W'(PAGE_BYTES - 1)) begin
                        r_d.col = '0;
                        if (r_q.page == PAGE_W'(PAGES - 1)) begin
                            r_d.st = SEQ_DONE;
                        end else begin
                            r_d.page = r_q.page + PAGE_W'(1);
                            r_d.cle  = 1'b1;
                            r_d.oe   = 1'b1;
                            r_d.dout = CMD_READ_AREA0;
                            r_d.st   = SEQ_CMD;
                        end
                    end else begin
                        r_d.col = r_q.col + COL_W'(1);
                    end
                end
            end
            SEQ_DONE: begin
                r_d.ce_n = 1'b1;
                r_d.rel  = 1'b1;
            end
            default: begin
                r_d.ce_n = 1'b1;
                r_d.cle  = 1'b0;
                r_d.ale  = 1'b0;
                r_d.oe   = 1'b0;
                r_d.err  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= SEQ_START;
            r_q.ce_n      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign nf_data_o   = r_q.dout;
    assign nf_data_oe  = r_q.oe;
    assign nf_cle      = r_q.cle;
    assign nf_ale      = r_q.ale;
    assign nf_ce_n     = r_q.ce_n;
    assign nf_we_n     = (r_q.st == SEQ_READ) ? 1'b1 : stb_n;
    assign nf_re_n     = (r_q.st == SEQ_READ) ? stb_n : 1'b1;
    assign ram_we      = r_q.ram_we;
    assign ram_addr    = 12'(r_q.ram_addr);
    assign ram_wdata   = r_q.ram_wdata;
    assign cpu_release = r_q.rel;
    assign load_error  = r_q.err;

endmodule

// File: rtl/nbl_checker.sv
module nbl_checker #(
    parameter int STROBE_HOLD = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        nf_cle,
    input logic        nf_ale,
    input logic        nf_we_n,
    input logic        nf_re_n,
    input logic        nf_ce_n,
    input logic        nf_rb,
    input logic        ram_we,
    input logic [11:0] ram_addr,
    input logic        cpu_release,
    input logic        load_error
);

    logic [7:0] re_lo_q, we_lo_q;
    logic       last_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            re_lo_q     <= '0;
            we_lo_q     <= '0;
            last_seen_q <= 1'b0;
        end else begin
            re_lo_q <= nf_re_n ? 8'd0 : ((re_lo_q == 8'hff) ? re_lo_q : re_lo_q + 8'd1);
            we_lo_q <= nf_we_n ? 8'd0 : ((we_lo_q == 8'hff) ? we_lo_q : we_lo_q + 8'd1);
            if (ram_we && ram_addr == 12'hfff) last_seen_q <= 1'b1;
        end
    end

    // R1
    strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    // R4
    read_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> nf_rb);

    // R6
    re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_re_n) |-> (re_lo_q == 8'(STROBE_HOLD)));

    // R6
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_we_n) |-> (we_lo_q == 8'(STROBE_HOLD)));

    // R8
    release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_release) |-> last_seen_q);

    // R8
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_release |=> cpu_release);

    // R8
    no_write_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_release |-> (!ram_we && nf_ce_n));

    // R9
    error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |=> (load_error && !cpu_release));

    // R9
    error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |-> (!ram_we && nf_re_n && nf_we_n));

endmodule

bind nand_boot_loader nbl_checker #(.STROBE_HOLD(STROBE_HOLD)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .nf_cle      (nf_cle),
    .nf_ale      (nf_ale),
    .nf_we_n     (nf_we_n),
    .nf_re_n     (nf_re_n),
    .nf_ce_n     (nf_ce_n),
    .nf_rb       (nf_rb),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .cpu_release (cpu_release),
    .load_error  (load_error)
);

// File: tb/nand_boot_loader_tb_top.sv
`timescale 1ns/1ps
module nand_boot_loader_tb_top;

    localparam int HOLD     = 2;
    localparam int RB_LIMIT = 300;
    localparam int PAGES    = 8;
    localparam int PB       = 512;
    localparam int BUSY_CYC = 20;
    localparam int TOTAL    = PAGES * PB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  nf_data_o, nf_data_i;
    logic        nf_data_oe, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_ce_n;
    logic        nf_rb = 1'b1;
    logic        ram_we, cpu_release, load_error;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata;

    always #2 clk = ~clk;

    nand_boot_loader #(
        .PAGES(PAGES), .PAGE_BYTES(PB), .STROBE_HOLD(HOLD),
        .RB_LIMIT(RB_LIMIT), .RB_SYNC(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .nf_data_o(nf_data_o), .nf_data_oe(nf_data_oe), .nf_data_i(nf_data_i),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_ce_n(nf_ce_n), .nf_rb(nf_rb),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .cpu_release(cpu_release), .load_error(load_error)
    );

    int vectors = 0;
    int miscompares = 0;
    bit summary_done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int p, input int c);
        return 8'((p * 37 + c * 7 + (c / 256) * 101) % 256);
    endfunction

    typedef struct { int addr; int data; } item_t;
    item_t sbq[$];

    // model state
    int  mode = 0;
    int  cur_page = 0, col = 0, acnt = 0, exp_page = 0;
    int  reads_in_page = 0, writes_seen = 0;
    int  ab[4];
    bit  ready_ok = 0, busy_req = 0, rel_seen = 0;
    int  re_lo = 0, re_hi = 0;

    assign nf_data_i = pat(cur_page, col);

    task automatic push_expected();
        for (int p = 0; p < PAGES; p++)
            for (int c = 0; c < PB; c++)
                sbq.push_back('{p * PB + c, int'(pat(p, c))});
    endtask

    // NAND model: command / address latch
    always @(posedge nf_we_n) begin
        if (rst_n && nf_ce_n === 1'b0) begin
            if (nf_cle) begin
                chk(nf_data_o == 8'h00, "R2 command byte", nf_data_o, 0);
                if (exp_page > 0) chk(reads_in_page == PB, "R5 reads per page", reads_in_page, PB);
                acnt = 0; reads_in_page = 0; ready_ok = 0;
            end else if (nf_ale) begin
                if (acnt < 4) ab[acnt] = int'(nf_data_o);
                acnt++;
                if (acnt == 4) begin
                    chk(ab[0] == 0, "R3 column byte", ab[0], 0);
                    chk((ab[3] << 16 | ab[2] << 8 | ab[1]) == exp_page, "R10 row order",
                        ab[3] << 16 | ab[2] << 8 | ab[1], exp_page);
                    cur_page = ab[3] << 16 | ab[2] << 8 | ab[1];
                    col = 0;
                    exp_page++;
                    busy_req = 1;
                end else if (acnt > 4) begin
                    chk(0, "R3 extra address byte", acnt, 4);
                end
            end
        end
    end

    // NAND model: busy phase
    initial begin
        forever begin
            @(negedge clk);
            if (busy_req) begin
                busy_req = 0;
                if (mode == 0) begin
                    nf_rb = 1'b0;
                    repeat (BUSY_CYC) @(negedge clk);
                    nf_rb = 1'b1;
                    ready_ok = 1;
                end else if (mode == 2) begin
                    nf_rb = 1'b0;
                end
            end
        end
    end

    always @(negedge nf_re_n)
        if (rst_n && nf_ce_n === 1'b0)
            chk(ready_ok && nf_rb, "R4 read before ready", int'(ready_ok), 1);

    always @(posedge nf_re_n)
        if (rst_n && nf_ce_n === 1'b0) begin
            col++;
            reads_in_page++;
        end

    // monitor: scoreboard, strobe widths, release ordering
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_we) begin
                writes_seen++;
                if (sbq.size() == 0) begin
                    chk(0, "R7 unexpected write", int'(ram_addr), -1);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(int'(ram_addr) == it.addr, "R7 write address", int'(ram_addr), it.addr);
                    chk(int'(ram_wdata) == it.data, "R5 write data", int'(ram_wdata), it.data);
                end
            end
            if (cpu_release && !rel_seen) begin
                rel_seen = 1;
                chk(sbq.size() == 0 && !ram_we, "R8 release before last write", sbq.size(), 0);
            end
            if (!nf_re_n) begin
                if (re_lo == 0 && re_hi != 0 && re_hi < HOLD)
                    chk(0, "R6 read high gap", re_hi, HOLD);
                re_lo++; re_hi = 0;
            end else begin
                if (re_lo != 0) chk(re_lo == HOLD, "R6 read low width", re_lo, HOLD);
                re_lo = 0;
                if (re_hi < 1000) re_hi++;
            end
        end
    end

    task automatic apply_reset(input int m);
        rst_n = 1'b0;
        mode = m;
        nf_rb = 1'b1;
        cur_page = 0; col = 0; acnt = 0; exp_page = 0;
        reads_in_page = 0; writes_seen = 0;
        ready_ok = 0; busy_req = 0; rel_seen = 0; re_lo = 0; re_hi = 0;
        sbq.delete();
        repeat (4) @(negedge clk);
        chk(!cpu_release && !load_error && !ram_we && !nf_cle && !nf_ale,
            "R1 reset outputs low", int'({cpu_release, load_error, ram_we, nf_cle, nf_ale}), 0);
        chk(nf_ce_n && nf_we_n && nf_re_n, "R1 reset strobes high",
            int'({nf_ce_n, nf_we_n, nf_re_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_release && !load_error, "R1 outputs after reset",
            int'({cpu_release, load_error}), 0);
    endtask

    initial begin
        // full load
        apply_reset(0);
        push_expected();
        for (int i = 0; i < 60000 && !cpu_release; i++) @(negedge clk);
        chk(cpu_release, "R8 release asserted", int'(cpu_release), 1);
        chk(writes_seen == TOTAL, "R7 write count", writes_seen, TOTAL);
        chk(reads_in_page == PB, "R5 reads last page", reads_in_page, PB);
        chk(exp_page == PAGES, "R10 pages loaded", exp_page, PAGES);
        chk(!load_error, "R9 no error on good device", int'(load_error), 0);
        repeat (50) @(negedge clk);
        chk(cpu_release && nf_ce_n, "R8 release held, chip deselected",
            int'({cpu_release, nf_ce_n}), 3);
        chk(writes_seen == TOTAL, "R8 no write after release", writes_seen, TOTAL);

        // device never enters busy
        apply_reset(1);
        for (int i = 0; i < RB_LIMIT + 200 && !load_error; i++) @(negedge clk);
        chk(load_error, "R9 timeout waiting for busy", int'(load_error), 1);
        repeat (100) @(negedge clk);
        chk(!cpu_release && load_error && nf_ce_n, "R9 held after timeout",
            int'({cpu_release, load_error, nf_ce_n}), 3);
        chk(writes_seen == 0, "R9 no writes after timeout", writes_seen, 0);

        // device stuck busy
        apply_reset(2);
        for (int i = 0; i < RB_LIMIT + 200 && !load_error; i++) @(negedge clk);
        chk(load_error, "R9 timeout waiting for ready", int'(load_error), 1);
        repeat (100) @(negedge clk);
        chk(!cpu_release && nf_re_n, "R9 no read after stuck busy",
            int'({cpu_release, nf_re_n}), 1);
        chk(writes_seen == 0, "R9 no writes stuck busy", writes_seen, 0);

        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
        $finish;
    end

endmodule